// File: doc/BRIEF.md
# Character Overlay Window Generator

This block lays a text window over a video stream. It takes its timing from the host's horizontal and vertical sync, whose active level can be inverted per axis. The window sits at a programmable pixel and row offset from the start of each sync, and a programmable divider turns system clocks into pixel clocks. The window holds a 256 x 128 pixel active area, which is 32 columns by 16 rows of 8 x 8 character cells, with a 4-pixel border on every side. The block drives a `window` flag, which the downstream mixer uses to tint the picture, and a one-bit `pixel` that carries the glyph foreground.

A CPU reaches the block through a small register port. The port has a 9-bit byte address, 16-bit write data and two write strobes: one for the control registers and one for the 512-byte text memory. Reads are combinational from the address and need no handshake. Character codes in the text memory select 8 x 8 glyphs in a 1024 x 8 glyph store. That store is filled through a separate load port. Two read-only addresses return sync-duration measurements that another block makes.

Top module: `txt_overlay`

## Requirements
- R1: A synchronous active-low reset clears every register. After reset, `ovl_on`, `ovl_window` and `ovl_pixel` are low and the writable registers read as zero.
- R2: Register map. Byte offset 0 holds the X position (12 bits). Offset 4 holds the Y position (12 bits). Offset 8 holds the clocks-per-pixel count (8 bits). Offset 20 holds the control register (3 bits). Each register reads back zero-extended. Any other offset except 12 and 16 reads zero. The whole 9-bit address is compared.
- R3: Offset 12 reads `meas_h` and offset 16 reads `meas_v`. Writes to these offsets change no register.
- R4: When `chr_we` is high, the clock edge stores `bus_wdata[7:0]` into text memory at `bus_addr`. `chr_rdata` always shows the text memory entry at `bus_addr`.
- R5: Control bit 0 drives `ovl_on`. While it is clear, `ovl_window` and `ovl_pixel` are low.
- R6: Control bit 1 inverts the horizontal sync polarity and bit 2 inverts the vertical sync polarity. A sync starts on the first clock at which the input is at its active level (low when not inverted).
- R7: X advances once every N clocks, where N is the clocks-per-pixel count and 0 acts as 1. The divider restarts at each horizontal sync start.
- R8: At a horizontal sync start, X loads -4 minus the X position. At a vertical sync start, Y loads -4 minus the Y position. Y rises by one at each horizontal sync start. Both counters are 12-bit signed and hold at +2047.
- R9: `ovl_window` is high when X lies in -4..259 and Y lies in -4..131. All video outputs show the counter values from two clocks earlier.
- R10: The text address is {Y[6:3], X[7:3]}. The glyph byte address is {code[6:0], Y[2:0]} and the pixel is bit X[2:0] of that byte. The load port writes whole glyph bytes.
- R11: `ovl_pixel` is the glyph bit gated by the window and by X in 0..255 and Y in 0..127. Border pixels are therefore never lit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hs_n | input | 1 | Horizontal sync from host video |
| vs_n | input | 1 | Vertical sync from host video |
| bus_addr | input | 9 | CPU byte address |
| bus_wdata | input | 16 | CPU write data |
| reg_we | input | 1 | Register write strobe |
| chr_we | input | 1 | Text memory write strobe |
| meas_h | input | 16 | Horizontal sync measurement, read at offset 12 |
| meas_v | input | 16 | Vertical sync measurement, read at offset 16 |
| rom_ld_we | input | 1 | Glyph store load strobe |
| rom_ld_addr | input | 10 | Glyph byte address {code, row} |
| rom_ld_data | input | 8 | Glyph byte, bit i is column i |
| reg_rdata | output | 16 | Register read data |
| chr_rdata | output | 8 | Text memory read data |
| ovl_on | output | 1 | Overlay enabled |
| ovl_window | output | 1 | Window, border included |
| ovl_pixel | output | 1 | Glyph foreground pixel |

## Verification
The readback properties assume the CPU holds `bus_addr` steady for the cycle after a write when it wants to observe the result. They also assume the two write strobes are never high together. The bench drives one strobe at a time and reads only after the write has completed. The timing checks assume the programmed positions stay below 2044, so the loaded counters never wrap, and that sync pulses are at least one clock apart. The stimulus uses short one-clock pulses with small offsets. Each polarity change is made while the sync inputs already sit at the new idle level, so no start is detected by mistake.

// File: rtl/txt_overlay_pkg.sv
// Shared constants and the configuration record of the text overlay.
// Assumes 8x8 glyphs and a 32x16 character grid.
package txt_overlay_pkg;
    localparam int ADDR_W     = 9;
    localparam int DATA_W     = 16;
    localparam int CNT_W      = 12;
    localparam int DIV_W      = 8;
    localparam int CHAR_W     = 8;
    localparam int CODE_W     = 7;
    localparam int GLYPH_LOG2 = 3;
    localparam int COLS_LOG2  = 5;
    localparam int ROWS_LOG2  = 4;
    localparam int BORDER     = 4;
    localparam int CTRL_W     = 3;

    localparam logic [ADDR_W-1:0] OFS_XPOS  = 9'd0;
    localparam logic [ADDR_W-1:0] OFS_YPOS  = 9'd4;
    localparam logic [ADDR_W-1:0] OFS_DIV   = 9'd8;
    localparam logic [ADDR_W-1:0] OFS_HMEAS = 9'd12;
    localparam logic [ADDR_W-1:0] OFS_VMEAS = 9'd16;
    localparam logic [ADDR_W-1:0] OFS_CTRL  = 9'd20;

    typedef struct packed {
        logic [CNT_W-1:0] xpos;
        logic [CNT_W-1:0] ypos;
        logic [DIV_W-1:0] div;
        logic             inv_v;
        logic             inv_h;
        logic             en;
    } ovl_cfg_t;
endpackage

// File: rtl/ovl_regs.sv
// Control register bank of the overlay.
// Decodes the full byte address, stores position, divider and control
// fields, and returns read data combinationally. Assumes one write strobe at a time.
module ovl_regs
    import txt_overlay_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              we,
    input  logic [DATA_W-1:0] meas_h,
    input  logic [DATA_W-1:0] meas_v,
    output ovl_cfg_t          cfg,
    output logic [DATA_W-1:0] rdata
);
    localparam int PAD_CNT  = DATA_W - CNT_W;
    localparam int PAD_DIV  = DATA_W - DIV_W;
    localparam int PAD_CTRL = DATA_W - CTRL_W;

    // Register writes, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (we) begin
            case (addr)
                OFS_XPOS: cfg.xpos <= wdata[CNT_W-1:0];
                OFS_YPOS: cfg.ypos <= wdata[CNT_W-1:0];
                OFS_DIV:  cfg.div  <= wdata[DIV_W-1:0];
                OFS_CTRL: begin
                    cfg.en    <= wdata[0];
                    cfg.inv_h <= wdata[1];
                    cfg.inv_v <= wdata[2];
                end
                default: ;
            endcase
        end
    end

    // Passive read multiplexer.
    always_comb begin
        case (addr)
            OFS_XPOS:  rdata = {{PAD_CNT{1'b0}}, cfg.xpos};
            OFS_YPOS:  rdata = {{PAD_CNT{1'b0}}, cfg.ypos};
            OFS_DIV:   rdata = {{PAD_DIV{1'b0}}, cfg.div};
            OFS_HMEAS: rdata = meas_h;
            OFS_VMEAS: rdata = meas_v;
            OFS_CTRL:  rdata = {{PAD_CTRL{1'b0}}, cfg.inv_v, cfg.inv_h, cfg.en};
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/ovl_timing.sv
// Sync edge detection, pixel divider and the two window position counters.
// The counters load minus border minus position at their sync start and then
// count up, holding at the largest positive value. Assumes positions below 2044.
module ovl_timing
    import txt_overlay_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hs_n,
    input  logic             vs_n,
    input  logic             inv_h,
    input  logic             inv_v,
    input  logic [CNT_W-1:0] xpos,
    input  logic [CNT_W-1:0] ypos,
    input  logic [DIV_W-1:0] div,
    output logic [CNT_W-1:0] xcnt,
    output logic [CNT_W-1:0] ycnt
);
    localparam logic [CNT_W-1:0] CNT_HOLD  = {1'b0, {(CNT_W-1){1'b1}}};
    localparam logic [CNT_W-1:0] CNT_START = CNT_W'(-BORDER);

    logic             hs_act, vs_act, hs_q, vs_q;
    logic             hs_start, vs_start, tick;
    logic [DIV_W-1:0] div_cnt;
    logic [DIV_W:0]   div_nxt;
    logic [CNT_W-1:0] xload, yload;

    assign hs_act   = (~hs_n) ^ inv_h;
    assign vs_act   = (~vs_n) ^ inv_v;
    assign hs_start = hs_act & ~hs_q;
    assign vs_start = vs_act & ~vs_q;
    assign div_nxt  = {1'b0, div_cnt} + (DIV_W+1)'(1);
    assign tick     = div_nxt >= {1'b0, div};
    assign xload    = CNT_START - xpos;
    assign yload    = CNT_START - ypos;

    // Remember the previous sync levels for start detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_q <= 1'b0;
            vs_q <= 1'b0;
        end else begin
            hs_q <= hs_act;
            vs_q <= vs_act;
        end
    end

    // Clocks-per-pixel divider, realigned at every line start.
    always_ff @(posedge clk) begin
        if (!rst_n || hs_start || tick) div_cnt <= '0;
        else                            div_cnt <= div_nxt[DIV_W-1:0];
    end

    // Horizontal window counter.
    always_ff @(posedge clk) begin
        if (!rst_n)                         xcnt <= CNT_HOLD;
        else if (hs_start)                  xcnt <= xload;
        else if (tick && xcnt != CNT_HOLD)  xcnt <= xcnt + CNT_W'(1);
    end

    // Vertical window counter, one step per line.
    always_ff @(posedge clk) begin
        if (!rst_n)                             ycnt <= CNT_HOLD;
        else if (vs_start)                      ycnt <= yload;
        else if (hs_start && ycnt != CNT_HOLD)  ycnt <= ycnt + CNT_W'(1);
    end
endmodule

// File: rtl/ovl_char_ram.sv
// Text memory: CPU port with write and combinational read, and a video
// port with a registered read that returns the character code bits only.
module ovl_char_ram
    import txt_overlay_pkg::*;
#(
    parameter int DEPTH = 1 << (COLS_LOG2 + ROWS_LOG2),
    localparam int AW   = $clog2(DEPTH)
)(
    input  logic              clk,
    input  logic [AW-1:0]     cpu_addr,
    input  logic              cpu_we,
    input  logic [CHAR_W-1:0] cpu_wdata,
    output logic [CHAR_W-1:0] cpu_rdata,
    input  logic [AW-1:0]     vid_addr,
    output logic [CODE_W-1:0] vid_code
);
    logic [CHAR_W-1:0] mem [DEPTH];

    // CPU write and video read share one clocked process.
    always_ff @(posedge clk) begin
        if (cpu_we) mem[cpu_addr] <= cpu_wdata;
        vid_code <= mem[vid_addr][CODE_W-1:0];
    end

    assign cpu_rdata = mem[cpu_addr];
endmodule

// File: rtl/ovl_glyph_rom.sv
// Glyph store: one byte per glyph row, bit i is column i. A load port fills
// it. The read returns one registered pixel bit.
module ovl_glyph_rom
    import txt_overlay_pkg::*;
#(
    parameter int ROW_W = 1 << GLYPH_LOG2,
    localparam int WORDS = 1 << (CODE_W + GLYPH_LOG2),
    localparam int AW    = $clog2(WORDS)
)(
    input  logic                  clk,
    input  logic                  ld_we,
    input  logic [AW-1:0]         ld_addr,
    input  logic [ROW_W-1:0]      ld_data,
    input  logic [AW-1:0]         rd_addr,
    input  logic [GLYPH_LOG2-1:0] rd_col,
    output logic                  rd_bit
);
    logic [ROW_W-1:0] mem [WORDS];

    // Load writes and the pixel read.
    always_ff @(posedge clk) begin
        if (ld_we) mem[ld_addr] <= ld_data;
        rd_bit <= mem[rd_addr][rd_col];
    end
endmodule

// File: rtl/txt_overlay.sv
// Text overlay window generator, top level.
// Counters -> text memory (1 clock) -> glyph store (1 clock). The window and
// active masks travel through two matching pipeline stages.
module txt_overlay
    import txt_overlay_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hs_n,
    input  logic              vs_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              reg_we,
    input  logic              chr_we,
    input  logic [DATA_W-1:0] meas_h,
    input  logic [DATA_W-1:0] meas_v,
    input  logic              rom_ld_we,
    input  logic [9:0]        rom_ld_addr,
    input  logic [7:0]        rom_ld_data,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [CHAR_W-1:0] chr_rdata,
    output logic              ovl_on,
    output logic              ovl_window,
    output logic              ovl_pixel
);
    localparam int X_LOG2 = COLS_LOG2 + GLYPH_LOG2;
    localparam int Y_LOG2 = ROWS_LOG2 + GLYPH_LOG2;
    localparam int ACT_X  = 1 << X_LOG2;
    localparam int ACT_Y  = 1 << Y_LOG2;
    localparam logic signed [CNT_W-1:0] W_LO   = CNT_W'(-BORDER);
    localparam logic signed [CNT_W-1:0] X_HI   = CNT_W'(ACT_X + BORDER - 1);
    localparam logic signed [CNT_W-1:0] Y_HI   = CNT_W'(ACT_Y + BORDER - 1);
    localparam int STAGES = 2;

    ovl_cfg_t                 cfg;
    logic [CNT_W-1:0]         xcnt, ycnt;
    logic [CODE_W-1:0]        code;
    logic                     glyph_bit;
    logic                     win0, act0;
    logic [GLYPH_LOG2-1:0]    xcol1, yrow1;
    logic [STAGES-1:0]        win_pipe, act_pipe;

    ovl_regs u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .we     (reg_we),
        .meas_h (meas_h),
        .meas_v (meas_v),
        .cfg    (cfg),
        .rdata  (reg_rdata)
    );

    ovl_timing u_timing (
        .clk   (clk),
        .rst_n (rst_n),
        .hs_n  (hs_n),
        .vs_n  (vs_n),
        .inv_h (cfg.inv_h),
        .inv_v (cfg.inv_v),
        .xpos  (cfg.xpos),
        .ypos  (cfg.ypos),
        .div   (cfg.div),
        .xcnt  (xcnt),
        .ycnt  (ycnt)
    );

    ovl_char_ram u_text (
        .clk       (clk),
        .cpu_addr  (bus_addr),
        .cpu_we    (chr_we),
        .cpu_wdata (bus_wdata[CHAR_W-1:0]),
        .cpu_rdata (chr_rdata),
        .vid_addr  ({ycnt[Y_LOG2-1:GLYPH_LOG2], xcnt[X_LOG2-1:GLYPH_LOG2]}),
        .vid_code  (code)
    );

    ovl_glyph_rom u_glyph (
        .clk     (clk),
        .ld_we   (rom_ld_we),
        .ld_addr (rom_ld_addr),
        .ld_data (rom_ld_data),
        .rd_addr ({code, yrow1}),
        .rd_col  (xcol1),
        .rd_bit  (glyph_bit)
    );

    // Window and active-area decode on the raw counters.
    always_comb begin
        win0 = ($signed(xcnt) >= W_LO) && ($signed(xcnt) <= X_HI) &&
               ($signed(ycnt) >= W_LO) && ($signed(ycnt) <= Y_HI);
        act0 = (xcnt[CNT_W-1:X_LOG2] == '0) && (ycnt[CNT_W-1:Y_LOG2] == '0);
    end

    // Glyph row and column follow the text memory read by one clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xcol1 <= '0;
            yrow1 <= '0;
        end else begin
            xcol1 <= xcnt[GLYPH_LOG2-1:0];
            yrow1 <= ycnt[GLYPH_LOG2-1:0];
        end
    end

    // Mask delay line, one stage per memory read.
    for (genvar s = 0; s < STAGES; s++) begin : g_mask
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                win_pipe[s] <= 1'b0;
                act_pipe[s] <= 1'b0;
            end else begin
                win_pipe[s] <= (s == 0) ? win0 : win_pipe[(s == 0) ? 0 : s-1];
                act_pipe[s] <= (s == 0) ? act0 : act_pipe[(s == 0) ? 0 : s-1];
            end
        end
    end

    assign ovl_on     = cfg.en;
    assign ovl_window = win_pipe[STAGES-1] & cfg.en;
    assign ovl_pixel  = glyph_bit & act_pipe[STAGES-1] & ovl_window;
endmodule

// File: rtl/txt_overlay_chk.sv
// Property checker for the text overlay, bound to every instance.
// Assumes the address is held for the cycle after a write that is observed.
module txt_overlay_chk
    import txt_overlay_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              reg_we,
    input logic              chr_we,
    input logic [DATA_W-1:0] meas_h,
    input logic [DATA_W-1:0] reg_rdata,
    input logic [CHAR_W-1:0] chr_rdata,
    input logic              ovl_on,
    input logic              ovl_window,
    input logic              ovl_pixel
);
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!ovl_on && !ovl_window && !ovl_pixel));

    p_xpos_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && bus_addr == OFS_XPOS) |=>
        (bus_addr != OFS_XPOS || reg_rdata == {4'h0, $past(bus_wdata[CNT_W-1:0])}));

    p_unmapped_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 9'd24) |-> (reg_rdata == '0));

    p_meas_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFS_HMEAS) |-> (reg_rdata == meas_h));

    p_text_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        chr_we |=> (bus_addr != $past(bus_addr) || chr_rdata == $past(bus_wdata[CHAR_W-1:0])));

    p_enable_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && bus_addr == OFS_CTRL) |=> (ovl_on == $past(bus_wdata[0])));

    p_dark_when_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !ovl_on |-> (!ovl_window && !ovl_pixel));
endmodule

bind txt_overlay txt_overlay_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .reg_we     (reg_we),
    .chr_we     (chr_we),
    .meas_h     (meas_h),
    .reg_rdata  (reg_rdata),
    .chr_rdata  (chr_rdata),
    .ovl_on     (ovl_on),
    .ovl_window (ovl_window),
    .ovl_pixel  (ovl_pixel)
);

// File: tb/sim_txt_overlay.sv
`timescale 1ns/1ps
module sim_txt_overlay;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hs_n = 1'b1, vs_n = 1'b1;
    logic [8:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic        reg_we = 1'b0, chr_we = 1'b0;
    logic [15:0] meas_h = 16'h5A3C, meas_v = 16'hC3A5;
    logic        rom_ld_we = 1'b0;
    logic [9:0]  rom_ld_addr = '0;
    logic [7:0]  rom_ld_data = '0;
    logic [15:0] reg_rdata;
    logic [7:0]  chr_rdata;
    logic        ovl_on, ovl_window, ovl_pixel;

    int checks = 0, errors = 0, pos = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    txt_overlay u0 (.*);

    // Register table: {offset, write data, expected readback}.
    localparam logic [40:0] VEC [9] = '{
        {9'd0,  16'h0ABC, 16'h0ABC},   // R2 X position
        {9'd0,  16'hFFFF, 16'h0FFF},   // R2 X position width
        {9'd4,  16'h1234, 16'h0234},   // R2 Y position width
        {9'd8,  16'h1234, 16'h0034},   // R2 divider width
        {9'd20, 16'h00FF, 16'h0007},   // R2 control width
        {9'd12, 16'hFFFF, 16'h5A3C},   // R3 horizontal measurement
        {9'd16, 16'h0000, 16'hC3A5},   // R3 vertical measurement
        {9'd24, 16'hBEEF, 16'h0000},   // R2 unmapped offset
        {9'd2,  16'h1111, 16'h0000}    // R2 unaligned offset
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [8:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic wr_chr(input logic [8:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; chr_we = 1'b1;
        @(negedge clk);
        chr_we = 1'b0;
    endtask

    task automatic rd_reg(input logic [8:0] a, input logic [15:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a;
        #1 chk(tag, 32'(reg_rdata), 32'(exp));
    endtask

    // One-clock sync pulse at the given active level; leaves time just after E0.
    task automatic hs_pulse(input logic act_lvl);
        @(negedge clk); hs_n = act_lvl;
        @(negedge clk); hs_n = ~act_lvl;
        pos = 0;
    endtask

    task automatic vs_pulse(input logic act_lvl);
        @(negedge clk); vs_n = act_lvl;
        @(negedge clk); vs_n = ~act_lvl;
    endtask

    task automatic frame(input int lines, input logic hl, input logic vl);
        vs_pulse(vl);
        for (int i = 0; i < lines; i++) hs_pulse(hl);
    endtask

    task automatic goto(input int m);
        while (pos < m) begin
            @(negedge clk);
            pos++;
        end
    endtask

    task automatic vid(input int m, input logic ew, input logic ep, input string tag);
        goto(m);
        chk({tag, " window"}, 32'(ovl_window), 32'(ew));
        chk({tag, " pixel"},  32'(ovl_pixel),  32'(ep));
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        #1;
        chk("R1 ovl_on", 32'(ovl_on), 0);
        chk("R1 window", 32'(ovl_window), 0);
        chk("R1 pixel", 32'(ovl_pixel), 0);
        rd_reg(9'd0,  16'h0, "R1 xpos");
        rd_reg(9'd4,  16'h0, "R1 ypos");
        rd_reg(9'd8,  16'h0, "R1 div");
        rd_reg(9'd20, 16'h0, "R1 ctrl");

        // Table walk for R2 and R3
        foreach (VEC[i]) begin
            wr_reg(VEC[i][40:32], VEC[i][31:16]);
            rd_reg(VEC[i][40:32], VEC[i][15:0], $sformatf("R2/R3 entry %0d", i));
        end
        rd_reg(9'd0, 16'h0FFF, "R3 measurement writes leave X untouched");
        chk("R5 ovl_on follows bit 0", 32'(ovl_on), 1);

        // R4 text memory
        wr_chr(9'd0, 16'h01A5);
        wr_chr(9'd511, 16'h007E);
        @(negedge clk); bus_addr = 9'd0; #1 chk("R4 low byte at 0", 32'(chr_rdata), 32'h A5);
        @(negedge clk); bus_addr = 9'd511; #1 chk("R4 entry 511", 32'(chr_rdata), 32'h7E);

        // Clear both memories, then place glyph 0x41 row 2 = 0000_0101
        for (int a = 0; a < 512; a++) wr_chr(9'(a), 16'h0);
        for (int a = 0; a < 1024; a++) begin
            @(negedge clk); rom_ld_we = 1'b1; rom_ld_addr = 10'(a); rom_ld_data = 8'h00;
        end
        @(negedge clk); rom_ld_addr = {7'h41, 3'd2}; rom_ld_data = 8'b0000_0101;
        @(negedge clk); rom_ld_we = 1'b0;
        wr_chr(9'd0, 16'h0041);
        wr_chr(9'd1, 16'h0041);

        wr_reg(9'd0, 16'd0); wr_reg(9'd4, 16'd0); wr_reg(9'd8, 16'd1); wr_reg(9'd20, 16'd1);

        // Row Y=2: six line starts after frame start
        frame(6, 1'b0, 1'b0);
        vid(2,   1, 0, "R9 left border X=-4");
        vid(6,   1, 1, "R10 X=0 glyph bit0");
        vid(7,   1, 0, "R10 X=1 glyph bit1");
        vid(8,   1, 1, "R10 X=2 glyph bit2");
        vid(14,  1, 1, "R10 column 1 X=8");
        vid(15,  1, 0, "R10 column 1 X=9");
        vid(16,  1, 1, "R10 column 1 X=10");
        vid(264, 1, 0, "R11 right border X=258 masked");
        vid(265, 1, 0, "R9 X=259 inside window");
        vid(266, 0, 0, "R9 X=260 outside window");

        frame(3, 1'b0, 1'b0);
        vid(8, 1, 0, "R9 top border Y=-1");
        frame(134, 1'b0, 1'b0);
        vid(8, 1, 0, "R11 bottom border Y=130 masked");
        frame(136, 1'b0, 1'b0);
        vid(8, 0, 0, "R9 Y=132 outside window");

        // R5 disable
        wr_reg(9'd20, 16'd0);
        frame(6, 1'b0, 1'b0);
        vid(6, 0, 0, "R5 disabled X=0");
        chk("R5 ovl_on low", 32'(ovl_on), 0);

        // R7 divider of 2 and of 0
        wr_reg(9'd20, 16'd1); wr_reg(9'd8, 16'd2);
        frame(6, 1'b0, 1'b0);
        vid(13, 1, 0, "R7 div2 X=1");
        vid(14, 1, 1, "R7 div2 X=2 first clock");
        vid(15, 1, 1, "R7 div2 X=2 second clock");
        vid(16, 1, 0, "R7 div2 X=3");
        wr_reg(9'd8, 16'd0);
        frame(6, 1'b0, 1'b0);
        vid(7, 1, 0, "R7 div0 X=1");
        vid(8, 1, 1, "R7 div0 X=2");

        // R8 positions X=5, Y=3
        wr_reg(9'd8, 16'd1); wr_reg(9'd0, 16'd5); wr_reg(9'd4, 16'd3);
        frame(9, 1'b0, 1'b0);
        vid(10, 1, 0, "R8 X=-1 after offset");
        vid(11, 1, 1, "R8 X=0 after offset");
        frame(8, 1'b0, 1'b0);
        vid(11, 1, 0, "R8 Y=1 row blank");

        // R6 inverted polarity on both axes
        wr_reg(9'd0, 16'd0); wr_reg(9'd4, 16'd0);
        @(negedge clk); hs_n = 1'b0; vs_n = 1'b0;
        wr_reg(9'd20, 16'd7);
        frame(6, 1'b1, 1'b1);
        vid(6, 1, 1, "R6 inverted X=0");
        vid(7, 1, 0, "R6 inverted X=1");
        vid(8, 1, 1, "R6 inverted X=2");

        // R1 reset while running
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 window after reset", 32'(ovl_window), 0);
        chk("R1 ovl_on after reset", 32'(ovl_on), 0);
        rd_reg(9'd20, 16'h0, "R1 ctrl after reset");
        rd_reg(9'd8, 16'h0, "R1 div after reset");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule